// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control unit of a small 8-bit accumulator processor. It watches an active-low request line together with the interrupt-mask bit of the status register. At every instruction boundary it either passes the fetched opcode into the instruction register or, when a qualified request is waiting, substitutes the break opcode (0x00). A hardware request therefore has no separate path. The break opcode itself starts the shared entry sequence. That sequence writes the return address and status to the stack and fetches the new program counter from the vector at 0xFFFE/0xFFFF. A flag pushed with the status word tells a forced entry from a software break. The block also runs the pull sequence of the return opcode (0x40).

The surrounding datapath supplies the program counter, status and stack pointer. It takes back new values through three write strobes that pulse together in the last cycle of a sequence. While a sequence runs, the block drives the synchronous memory bus. Reads are combinational: read data belongs to the address driven in the same cycle. The busy output tells the ordinary fetch logic to hold off.

Top module: `intseq_unit`

## Requirements
- R1: The request counts as pending only once irq_n has been sampled low on 3 consecutive rising edges with the mask bit clear. Two low samples followed by a high sample leave it not pending.
- R2: While status bit 2 (interrupt mask) is set, a low irq_n never causes a forced entry.
- R3: The instruction register changes only on a cycle with op_boundary high and the block idle. It then takes op_fetched, or 0x00 when a request is pending. A pending request causes no bus activity before that boundary.
- R4: An op_boundary pulse while seq_active is high is ignored. The instruction register and the running sequence are unaffected.
- R5: Entry performs exactly three writes, to 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, in that order: return address high byte, return address low byte, status. SP is reloaded as SP-3.
- R6: For a software break (fetched opcode 0x00) the pushed return address is the break opcode's address plus 2. For a forced entry it is the address of the opcode that was not executed.
- R7: The pushed status equals the current status except for bit 4 (break). Bit 4 is 1 for a software break and 0 for a forced entry.
- R8: After the pushes the low byte is read from 0xFFFE and the high byte from 0xFFFF. That value is loaded into the program counter, and the status is reloaded with bit 2 set.
- R9: Opcode 0x40 reads the status from 0x0100+SP+1, the PC low byte from 0x0100+SP+2 and the PC high byte from 0x0100+SP+3. It reloads all three registers, with SP+3, so the pulled mask bit governs later requests.
- R10: seq_active rises in the cycle after the loading boundary and stays high for 6 cycles on entry and 4 cycles on return. Memory writes and the PC, status and SP strobes occur only while it is high.
- R11: During and right after reset, seq_active and mem_we are low and the instruction register holds 0xEA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Active-low interrupt request |
| op_boundary | input | 1 | Current instruction complete, next opcode on op_fetched |
| op_fetched | input | 8 | Opcode fetched at the boundary |
| pc_i | input | 16 | Program counter (address of op_fetched at a boundary) |
| status_i | input | 8 | Status register |
| sp_i | input | 8 | Stack pointer |
| mem_rdata | input | 8 | Memory read data for mem_addr |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| ir_q | output | 8 | Instruction register |
| pc_o | output | 16 | New program counter |
| pc_we | output | 1 | Program counter load strobe |
| status_o | output | 8 | New status value |
| status_we | output | 1 | Status load strobe |
| sp_o | output | 8 | New stack pointer |
| sp_we | output | 1 | Stack pointer load strobe |
| seq_active | output | 1 | Sequence running; ordinary fetch held off |

## Verification
A wrong qualification count or a bad mask gate shows at ir_q on the first cycle after the boundary: 0x00 appears where the fetched opcode belonged, or the reverse. A stack pointer or state that steps wrongly shows at once as a write with a wrong address or byte order, within the three cycles after the boundary. A wrong latched return address or break flag shows in the pushed bytes. Vector or pull errors only surface on the final strobe cycle, 6 or 4 cycles after the boundary, as a wrong PC, status or SP load, so the bench compares the register values handed back after each sequence.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PUSH_HI,
      S_PUSH_LO,
      S_PUSH_ST,
      S_VEC_LO,
      S_VEC_HI,
      S_PULL_ST,
      S_PULL_LO,
      S_PULL_HI,
      S_FINISH
   } seq_state_t;

   localparam logic [7:0] OP_BREAK  = 8'h00;
   localparam logic [7:0] OP_RETURN = 8'h40;

endpackage

// File: rtl/intseq_req_filter.sv
// Qualifies the active-low request: pending after REQ_SAMPLES consecutive
// low samples taken while the mask bit is clear.
module intseq_req_filter #(
   parameter int REQ_SAMPLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   input  logic masked,
   output logic pending
);
   logic qualify;
   assign qualify = ~irq_n & ~masked;

   generate
      if (REQ_SAMPLES == 1) begin : g_single
         logic seen_q;
         always_ff @(posedge clk) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= qualify;
         end
         assign pending = seen_q & ~masked;
      end else begin : g_count
         localparam int CW = $clog2(REQ_SAMPLES + 1);
         localparam logic [CW-1:0] LIMIT = CW'(REQ_SAMPLES);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             run_q <= '0;
            else if (!qualify)      run_q <= '0;
            else if (run_q != LIMIT) run_q <= run_q + 1'b1;
         end
         assign pending = (run_q == LIMIT) & ~masked;
      end
   endgenerate
endmodule

// File: rtl/intseq_fsm.sv
// Sequence controller: boundary decision, entry pushes, vector fetch,
// return pulls and the final register hand-back.
module intseq_fsm
   import intseq_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int IRQ_MASK_BIT = 2,
   parameter int BRK_BIT      = 4,
   parameter int BREAK_SKIP   = 2,
   parameter logic [DATA_W-1:0] RESET_IR = 8'hEA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pending,
   input  logic              op_boundary,
   input  logic [DATA_W-1:0] op_fetched,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] sp_i,
   input  logic [DATA_W-1:0] rdata,
   output seq_state_t        state_o,
   output logic [DATA_W-1:0] sp_cur,
   output logic [ADDR_W-1:0] ret_addr,
   output logic [DATA_W-1:0] push_status,
   output logic [DATA_W-1:0] ir_q,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] sp_o,
   output logic              pc_we,
   output logic              status_we,
   output logic              sp_we
);
   localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(BREAK_SKIP);

   seq_state_t        state_q;
   logic [DATA_W-1:0] sp_q, stat_q, lo_q, ir_r;
   logic [ADDR_W-1:0] ret_q, pc_q;
   logic              forced_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         ir_r     <= RESET_IR;
         sp_q     <= '0;
         stat_q   <= '0;
         lo_q     <= '0;
         ret_q    <= '0;
         pc_q     <= '0;
         forced_q <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (op_boundary) begin
                  ir_r     <= pending ? OP_BREAK : op_fetched;
                  sp_q     <= sp_i;
                  stat_q   <= status_i;
                  forced_q <= pending;
                  ret_q    <= pending ? pc_i : pc_i + SKIP;
                  if (pending || op_fetched == OP_BREAK) state_q <= S_PUSH_HI;
                  else if (op_fetched == OP_RETURN)      state_q <= S_PULL_ST;
               end
            end
            S_PUSH_HI: begin sp_q <= sp_q - 1'b1; state_q <= S_PUSH_LO; end
            S_PUSH_LO: begin sp_q <= sp_q - 1'b1; state_q <= S_PUSH_ST; end
            S_PUSH_ST: begin sp_q <= sp_q - 1'b1; state_q <= S_VEC_LO;  end
            S_VEC_LO:  begin lo_q <= rdata;       state_q <= S_VEC_HI;  end
            S_VEC_HI: begin
               pc_q                 <= {rdata, lo_q};
               stat_q[IRQ_MASK_BIT] <= 1'b1;
               state_q              <= S_FINISH;
            end
            S_PULL_ST: begin
               sp_q    <= sp_q + 1'b1;
               stat_q  <= rdata;
               state_q <= S_PULL_LO;
            end
            S_PULL_LO: begin
               sp_q    <= sp_q + 1'b1;
               lo_q    <= rdata;
               state_q <= S_PULL_HI;
            end
            S_PULL_HI: begin
               sp_q    <= sp_q + 1'b1;
               pc_q    <= {rdata, lo_q};
               state_q <= S_FINISH;
            end
            S_FINISH: state_q <= S_IDLE;
            default:  state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      push_status          = stat_q;
      push_status[BRK_BIT] = ~forced_q;
   end

   assign state_o   = state_q;
   assign sp_cur    = sp_q;
   assign ret_addr  = ret_q;
   assign ir_q      = ir_r;
   assign pc_o      = pc_q;
   assign status_o  = stat_q;
   assign sp_o      = sp_q;
   assign pc_we     = (state_q == S_FINISH);
   assign status_we = (state_q == S_FINISH);
   assign sp_we     = (state_q == S_FINISH);
endmodule

// File: rtl/intseq_bus.sv
// Bus cycle generator: address, write data and write enable per state.
module intseq_bus
   import intseq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0]        VECTOR_LO  = 16'hFFFE
) (
   input  seq_state_t        state,
   input  logic [DATA_W-1:0] sp_cur,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [DATA_W-1:0] push_status,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we
);
   localparam logic [ADDR_W-1:0] VECTOR_HI = VECTOR_LO + 1'b1;

   logic [ADDR_W-1:0] push_slot, pull_slot;
   assign push_slot = {STACK_PAGE, sp_cur};
   assign pull_slot = {STACK_PAGE, sp_cur + 1'b1};

   always_comb begin
      addr  = '0;
      wdata = '0;
      we    = 1'b0;
      case (state)
         S_PUSH_HI: begin addr = push_slot; wdata = ret_addr[ADDR_W-1:DATA_W]; we = 1'b1; end
         S_PUSH_LO: begin addr = push_slot; wdata = ret_addr[DATA_W-1:0];      we = 1'b1; end
         S_PUSH_ST: begin addr = push_slot; wdata = push_status;               we = 1'b1; end
         S_VEC_LO:  addr = VECTOR_LO;
         S_VEC_HI:  addr = VECTOR_HI;
         S_PULL_ST, S_PULL_LO, S_PULL_HI: addr = pull_slot;
         default: ;
      endcase
   end
endmodule

// File: rtl/intseq_unit.sv
module intseq_unit
   import intseq_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int REQ_SAMPLES  = 3,
   parameter int IRQ_MASK_BIT = 2,
   parameter int BRK_BIT      = 4,
   parameter int BREAK_SKIP   = 2,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0]        VECTOR_LO  = 16'hFFFE,
   parameter logic [DATA_W-1:0]        RESET_IR   = 8'hEA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_n,
   input  logic              op_boundary,
   input  logic [DATA_W-1:0] op_fetched,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] sp_i,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] ir_q,
   output logic [ADDR_W-1:0] pc_o,
   output logic              pc_we,
   output logic [DATA_W-1:0] status_o,
   output logic              status_we,
   output logic [DATA_W-1:0] sp_o,
   output logic              sp_we,
   output logic              seq_active
);
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("intseq_unit: ADDR_W must be twice DATA_W");
   end
   if (REQ_SAMPLES < 1) begin : g_bad_samples
      $error("intseq_unit: REQ_SAMPLES must be at least 1");
   end
   if (IRQ_MASK_BIT >= DATA_W || BRK_BIT >= DATA_W || IRQ_MASK_BIT == BRK_BIT) begin : g_bad_bits
      $error("intseq_unit: status bit positions out of range or equal");
   end

   seq_state_t        state;
   logic              pending;
   logic [DATA_W-1:0] sp_cur, push_status;
   logic [ADDR_W-1:0] ret_addr;

   intseq_req_filter #(.REQ_SAMPLES(REQ_SAMPLES)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_n   (irq_n),
      .masked  (status_i[IRQ_MASK_BIT]),
      .pending (pending)
   );

   intseq_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_MASK_BIT(IRQ_MASK_BIT),
      .BRK_BIT(BRK_BIT), .BREAK_SKIP(BREAK_SKIP), .RESET_IR(RESET_IR)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pending     (pending),
      .op_boundary (op_boundary),
      .op_fetched  (op_fetched),
      .pc_i        (pc_i),
      .status_i    (status_i),
      .sp_i        (sp_i),
      .rdata       (mem_rdata),
      .state_o     (state),
      .sp_cur      (sp_cur),
      .ret_addr    (ret_addr),
      .push_status (push_status),
      .ir_q        (ir_q),
      .pc_o        (pc_o),
      .status_o    (status_o),
      .sp_o        (sp_o),
      .pc_we       (pc_we),
      .status_we   (status_we),
      .sp_we       (sp_we)
   );

   intseq_bus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STACK_PAGE(STACK_PAGE), .VECTOR_LO(VECTOR_LO)
   ) u_bus (
      .state       (state),
      .sp_cur      (sp_cur),
      .ret_addr    (ret_addr),
      .push_status (push_status),
      .addr        (mem_addr),
      .wdata       (mem_wdata),
      .we          (mem_we)
   );

   assign seq_active = (state != S_IDLE);
endmodule

// File: rtl/intseq_chk.sv
module intseq_chk #(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int IRQ_MASK_BIT = 2,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0]        VECTOR_LO  = 16'hFFFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] ir_q,
   input logic              pc_we,
   input logic [DATA_W-1:0] status_o,
   input logic              status_we,
   input logic              sp_we,
   input logic              seq_active
);
   // R10
   write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> seq_active);

   // R10
   load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we || status_we || sp_we) |-> seq_active);

   // R5
   stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));

   // R5
   push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

   // R8
   vector_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && ir_q == 8'h00) |-> ($past(mem_addr) == VECTOR_LO + 1'b1));

   // R8
   mask_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && ir_q == 8'h00) |-> status_o[IRQ_MASK_BIT]);

   // R4
   busy_holds_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_active |=> $stable(ir_q));
endmodule

bind intseq_unit intseq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_MASK_BIT(IRQ_MASK_BIT),
   .STACK_PAGE(STACK_PAGE), .VECTOR_LO(VECTOR_LO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
   .ir_q(ir_q), .pc_we(pc_we), .status_o(status_o), .status_we(status_we),
   .sp_we(sp_we), .seq_active(seq_active)
);

// File: tb/intseq_unit_test.sv
module intseq_unit_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, irq_n, op_boundary;
   logic [7:0]  op_fetched, status_i, sp_i, mem_rdata;
   logic [15:0] pc_i, mem_addr, pc_o;
   logic [7:0]  mem_wdata, ir_q, status_o, sp_o;
   logic        mem_we, pc_we, status_we, sp_we, seq_active;

   intseq_unit uut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .op_boundary(op_boundary),
      .op_fetched(op_fetched), .pc_i(pc_i), .status_i(status_i), .sp_i(sp_i),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .ir_q(ir_q), .pc_o(pc_o), .pc_we(pc_we),
      .status_o(status_o), .status_we(status_we), .sp_o(sp_o), .sp_we(sp_we),
      .seq_active(seq_active)
   );

   // datapath and memory model
   logic [15:0] dp_pc, tb_pc;
   logic [7:0]  dp_p, dp_sp, tb_p, tb_sp;
   logic        tb_set, tb_clr, tb_mw;
   logic [7:0]  tb_ma, tb_md;
   logic [7:0]  stk [256];
   logic [15:0] log_a [8];
   logic [7:0]  log_d [8];
   int          log_n;

   assign pc_i     = dp_pc;
   assign status_i = dp_p;
   assign sp_i     = dp_sp;

   always @(posedge clk) begin
      if (tb_set) begin
         dp_pc <= tb_pc; dp_p <= tb_p; dp_sp <= tb_sp;
      end else begin
         if (pc_we)     dp_pc <= pc_o;
         if (status_we) dp_p  <= status_o;
         if (sp_we)     dp_sp <= sp_o;
      end
      if (tb_clr) log_n <= 0;
      else if (mem_we) begin
         if (log_n < 8) begin
            log_a[log_n[2:0]] <= mem_addr;
            log_d[log_n[2:0]] <= mem_wdata;
         end
         log_n <= log_n + 1;
      end
      if (mem_we)     stk[mem_addr[7:0]] <= mem_wdata;
      else if (tb_mw) stk[tb_ma] <= tb_md;
   end

   always_comb begin
      if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
      else if (mem_addr == 16'hFFFE) mem_rdata = 8'h40;
      else if (mem_addr == 16'hFFFF) mem_rdata = 8'h80;
      else mem_rdata = 8'hEA;
   end

   int vectors = 0;
   int misses  = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic setup(input logic [15:0] pc, input logic [7:0] p, input logic [7:0] sp);
      @(negedge clk);
      tb_pc = pc; tb_p = p; tb_sp = sp; tb_set = 1'b1; tb_clr = 1'b1;
      @(negedge clk);
      tb_set = 1'b0; tb_clr = 1'b0;
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      tb_ma = a; tb_md = d; tb_mw = 1'b1;
      @(negedge clk);
      tb_mw = 1'b0;
   endtask

   task automatic boundary(input logic [7:0] op);
      @(negedge clk);
      op_boundary = 1'b1; op_fetched = op;
      @(negedge clk);
      op_boundary = 1'b0;
   endtask

   task automatic wait_done(output int cycles);
      cycles = 0;
      while (seq_active && cycles < 50) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic t_reset;
      chk("R11", "seq_active in reset", 32'(seq_active), 0);
      chk("R11", "mem_we in reset", 32'(mem_we), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "ir after reset", 32'(ir_q), 32'h EA);
      chk("R11", "seq_active after reset", 32'(seq_active), 0);
   endtask

   task automatic t_plain;
      setup(16'h0300, 8'h20, 8'hFF);
      boundary(8'hA9);
      chk("R3", "plain opcode loaded", 32'(ir_q), 32'h A9);
      chk("R3", "no sequence on plain opcode", 32'(seq_active), 0);
   endtask

   task automatic t_soft_break;
      int n;
      setup(16'h1234, 8'h20, 8'hFD);
      boundary(8'h00);
      chk("R10", "busy after break load", 32'(seq_active), 1);
      chk("R3", "break in ir", 32'(ir_q), 0);
      wait_done(n);
      chk("R10", "entry busy cycles", 32'(n), 6);
      chk("R5", "write count", 32'(log_n), 3);
      chk("R5", "push1 addr", 32'(log_a[0]), 32'h01FD);
      chk("R6", "push1 pc high", 32'(log_d[0]), 32'h12);
      chk("R5", "push2 addr", 32'(log_a[1]), 32'h01FC);
      chk("R6", "push2 pc low +2", 32'(log_d[1]), 32'h36);
      chk("R5", "push3 addr", 32'(log_a[2]), 32'h01FB);
      chk("R7", "soft status break=1", 32'(log_d[2]), 32'h30);
      chk("R8", "pc from vector", 32'(dp_pc), 32'h8040);
      chk("R8", "mask set", 32'(dp_p), 32'h24);
      chk("R5", "sp minus 3", 32'(dp_sp), 32'hFA);
   endtask

   task automatic t_hw_entry;
      int n;
      setup(16'h2000, 8'h31, 8'hF0);
      @(negedge clk); irq_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3", "no action before boundary", 32'(seq_active), 0);
      chk("R3", "no writes before boundary", 32'(log_n), 0);
      boundary(8'hA9);
      chk("R1", "forced break in ir", 32'(ir_q), 0);
      wait_done(n);
      irq_n = 1'b1;
      chk("R6", "hw pc high", 32'(log_d[0]), 32'h20);
      chk("R6", "hw pc low unadvanced", 32'(log_d[1]), 32'h00);
      chk("R7", "hw status break=0", 32'(log_d[2]), 32'h21);
      chk("R5", "hw last push addr", 32'(log_a[2]), 32'h01EE);
      chk("R8", "hw pc vector", 32'(dp_pc), 32'h8040);
      chk("R8", "hw mask set", 32'(dp_p), 32'h35);
      chk("R5", "hw sp", 32'(dp_sp), 32'hED);
   endtask

   task automatic t_qualify;
      int n;
      setup(16'h0400, 8'h20, 8'hFF);
      @(negedge clk); irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      irq_n = 1'b1; op_boundary = 1'b1; op_fetched = 8'hA9;
      @(negedge clk); op_boundary = 1'b0;
      chk("R1", "two low samples not pending", 32'(ir_q), 32'h A9);
      chk("R1", "no sequence after short pulse", 32'(seq_active), 0);
      @(negedge clk); irq_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      op_boundary = 1'b1; op_fetched = 8'hA9;
      @(negedge clk); op_boundary = 1'b0;
      chk("R1", "three low samples pending", 32'(ir_q), 0);
      wait_done(n);
      irq_n = 1'b1;
   endtask

   task automatic t_masked;
      setup(16'h0500, 8'h24, 8'hFF);
      @(negedge clk); irq_n = 1'b0;
      repeat (5) @(negedge clk);
      boundary(8'hA9);
      chk("R2", "masked request ignored", 32'(ir_q), 32'h A9);
      chk("R2", "masked no sequence", 32'(seq_active), 0);
      irq_n = 1'b1;
   endtask

   task automatic t_busy_ignore;
      int n;
      setup(16'h1000, 8'h20, 8'hFF);
      boundary(8'h00);
      boundary(8'hA9);
      chk("R4", "ir kept during sequence", 32'(ir_q), 0);
      wait_done(n);
      chk("R4", "sequence unaffected pc", 32'(dp_pc), 32'h8040);
      chk("R4", "sequence unaffected writes", 32'(log_n), 3);
   endtask

   task automatic t_return;
      int n;
      setup(16'h8040, 8'h24, 8'hFA);
      poke(8'hFB, 8'hC3);
      poke(8'hFC, 8'h78);
      poke(8'hFD, 8'h56);
      boundary(8'h40);
      chk("R10", "busy after return load", 32'(seq_active), 1);
      wait_done(n);
      chk("R10", "return busy cycles", 32'(n), 4);
      chk("R9", "status pulled", 32'(dp_p), 32'h C3);
      chk("R9", "pc pulled", 32'(dp_pc), 32'h5678);
      chk("R9", "sp plus 3", 32'(dp_sp), 32'hFD);
      chk("R9", "return does not write", 32'(log_n), 0);
   endtask

   task automatic t_round_trip;
      int n;
      setup(16'h3456, 8'h20, 8'hFF);
      @(negedge clk); irq_n = 1'b0;
      repeat (4) @(negedge clk);
      boundary(8'hA9);
      wait_done(n);
      irq_n = 1'b1;
      boundary(8'h40);
      wait_done(n);
      chk("R9", "round trip pc", 32'(dp_pc), 32'h3456);
      chk("R9", "round trip status", 32'(dp_p), 32'h20);
      chk("R9", "round trip sp", 32'(dp_sp), 32'hFF);
      @(negedge clk); irq_n = 1'b0;
      repeat (4) @(negedge clk);
      boundary(8'hA9);
      chk("R9", "restored mask admits request", 32'(ir_q), 0);
      wait_done(n);
      irq_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         vectors++;
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; irq_n = 1'b1; op_boundary = 1'b0; op_fetched = 8'hEA;
      tb_set = 1'b1; tb_clr = 1'b1; tb_mw = 1'b0; tb_ma = 8'h00; tb_md = 8'h00;
      tb_pc = 16'h0000; tb_p = 8'h24; tb_sp = 8'hFF;
      repeat (3) @(negedge clk);
      tb_set = 1'b0; tb_clr = 1'b0;
      t_reset();
      t_plain();
      t_soft_break();
      t_hw_entry();
      t_qualify();
      t_masked();
      t_busy_ignore();
      t_return();
      t_round_trip();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule